// File: doc/BRIEF.md
# Parallel Polyphase Sine Synthesizer

This block produces a group of sine samples on every fabric clock for a converter that runs several times faster than the fabric. The default group has eight samples, so a 200 MHz fabric clock feeds a 1.6 GSa/s converter. Software supplies a tuning word. The tuning word is the phase step between two consecutive output samples at the full interleaved rate, that is (f_out / f_sample) × 2^32.

One shared 32-bit accumulator wraps modulo 2^32 and advances by eight tuning words per clock. Each lane treats itself as one polyphase component. Lane k reads the accumulator plus k tuning words. It keeps the top 12 bits of that phase and looks the result up in a quarter-wave table with 1024 entries. Because each lane's phase is built this way, tones above the fabric clock, up to half the sample rate, come out at the right frequency and do not fold back to an alias.

A load pulse stores a new tuning word and zeroes the accumulator, so the first group after a load always starts at phase zero. Enable starts the stream and pauses it without losing phase.

Top module: `pdds_gen`

## Requirements
- R1: While reset is asserted, `sampleValid` is 0 and every lane of `samplesOut` is 0.
- R2: `sampleValid` goes to 1 exactly 3 clocks after `enable` is first sampled high following a load. It goes back to 0 exactly 3 clocks after `enable` is sampled low. It stays at 1 while `enable` stays high.
- R3: Let n be the index of a valid group, counted from 0 after the most recent load. Lane k of group n then equals S(p), where p is the top 12 bits of ((8n+k)·W mod 2^32) and S(p) = round(32767·sin(2π(p+0.5)/4096)), within ±1 LSB.
- R4: Lane k occupies bits [16k+15:16k] of `samplesOut` and is a two's-complement value. Lane 0 is the earliest sample of the group and lane 7 is the latest.
- R5: A load pulse, taken while `enable` is low, stores `tuningWord` and zeroes the accumulator. Lane 0 of the next valid group is then S(0).
- R6: While `enable` is low the accumulator holds its value. The first group after enable returns continues the sequence of R3 with no gap.
- R7: With W = 2^29 (one eighth of the sample rate), every valid group is identical to the group before it.
- R8: With W = 2^31 (half the sample rate), each lane k+1 equals the exact negation of lane k, giving two samples per period.
- R9: Tuning words of 2^31 and above wrap modulo 2^32. For such words R3 holds as written, so the block produces the mirrored (negative) frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the accumulator and mark groups valid |
| loadStrobe | input | 1 | Store tuningWord and zero the accumulator |
| tuningWord | input | 32 | Per-sample phase step at the interleaved rate |
| samplesOut | output | 128 | Eight signed 16-bit samples, lane 0 in the low bits |
| sampleValid | output | 1 | The current group of samples is valid |

## Verification
A wrong lane offset or a wrong accumulator step shows in the very first valid group after a load, because group 0 already has a different phase in every lane. A wrong per-clock advance shows in group 1, one clock later. A bad quadrant mirror or a bad sign only shows when a lane's phase enters the affected quadrant. For that reason several tones are run long enough for every lane to sweep all four quadrants. An accumulator that slips during a pause shows in the first group after the block resumes.

// File: rtl/pdds_pkg.sv
package pdds_pkg;
  localparam int PHASE_W = 32;
  localparam int LANES   = 8;
  localparam int SAMP_W  = 16;
  localparam int TBL_W   = 12;

  typedef struct packed {
    logic loadWord;
    logic step;
  } pddsStrobes_t;
endpackage

// File: rtl/pdds_qsine_rom.sv
module pdds_qsine_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PORTS  = 8
) (
  input  logic [PORTS-1:0][ADDR_W-1:0] rdAddr,
  output logic [PORTS-1:0][DATA_W-1:0] rdData
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int FULL_PTS = DEPTH * 4;

  logic [DATA_W-1:0] romMem [DEPTH];

  // Quarter wave sampled at half-step offsets so mirroring is exact
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real ang;
      real amp;
      amp = real'((1 << (DATA_W - 1)) - 1);
      ang = 2.0 * 3.14159265358979323846 * (real'(i) + 0.5) / real'(FULL_PTS);
      romMem[i] = DATA_W'($rtoi($floor(amp * $sin(ang) + 0.5)));
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign rdData[p] = romMem[rdAddr[p]];
  end
endmodule

// File: rtl/pdds_ctrl.sv
module pdds_ctrl
  import pdds_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         loadStrobe,
  output pddsStrobes_t strobes,
  output logic         validOut
);
  logic [LATENCY-1:0] validPipe;

  assign strobes.loadWord = loadStrobe;
  assign strobes.step     = enable & ~loadStrobe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LATENCY-2:0], strobes.step};
  end

  assign validOut = validPipe[LATENCY-1];

  // R2: valid only rises after enable was high three clocks before
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(validOut) |-> $past(enable, 3));

  // R5: load and step never fire together
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadWord && strobes.step));
endmodule

// File: rtl/pdds_datapath.sv
module pdds_datapath
  import pdds_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  pddsStrobes_t            strobes,
  input  logic [PHASE_W-1:0]      tuningWord,
  output logic [LANES*SAMP_W-1:0] samplesOut
);
  localparam int LANE_BITS = $clog2(LANES);
  localparam int ROM_A_W   = TBL_W - 2;

  logic [PHASE_W-1:0] accReg;
  logic [PHASE_W-1:0] ftwReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg <= '0;
      ftwReg <= '0;
    end else if (strobes.loadWord) begin
      ftwReg <= tuningWord;
      accReg <= '0;
    end else if (strobes.step) begin
      accReg <= accReg + (ftwReg << LANE_BITS);
    end
  end

  logic [LANES-1:0][TBL_W-1:0]   phaseTop;
  logic [LANES-1:0][ROM_A_W-1:0] romAddr;
  logic [LANES-1:0][SAMP_W-1:0]  romData;
  logic [LANES-1:0][SAMP_W-1:0]  magReg;
  logic [LANES-1:0]              negReg;
  logic [LANES-1:0][SAMP_W-1:0]  sampReg;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] lanePhase;
    assign lanePhase = accReg + ftwReg * PHASE_W'(k);

    always_ff @(posedge clk) begin
      if (rst)               phaseTop[k] <= '0;
      else if (strobes.step) phaseTop[k] <= lanePhase[PHASE_W-1 -: TBL_W];
    end

    assign romAddr[k] = phaseTop[k][TBL_W-2] ? ~phaseTop[k][ROM_A_W-1:0]
                                             :  phaseTop[k][ROM_A_W-1:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        magReg[k]  <= '0;
        negReg[k]  <= 1'b0;
        sampReg[k] <= '0;
      end else begin
        magReg[k]  <= romData[k];
        negReg[k]  <= phaseTop[k][TBL_W-1];
        sampReg[k] <= negReg[k] ? (~magReg[k] + 1'b1) : magReg[k];
      end
    end

    assign samplesOut[k*SAMP_W +: SAMP_W] = sampReg[k];
  end

  pdds_qsine_rom #(.ADDR_W(ROM_A_W), .DATA_W(SAMP_W), .PORTS(LANES)) u_rom (
    .rdAddr (romAddr),
    .rdData (romData)
  );

  // R5: a load leaves the accumulator at zero
  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.loadWord) |-> accReg == '0);

  // R6: with no step and no load the accumulator is frozen
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobes.step) && !$past(strobes.loadWord)) |-> $stable(accReg));

  // R3: each step advances by one full group of per-sample increments
  assert_group_step_R3: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.step) |-> accReg == $past(accReg) + ($past(ftwReg) << LANE_BITS));
endmodule

// File: rtl/pdds_gen.sv
module pdds_gen
  import pdds_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    loadStrobe,
  input  logic [PHASE_W-1:0]      tuningWord,
  output logic [LANES*SAMP_W-1:0] samplesOut,
  output logic                    sampleValid
);
  pddsStrobes_t strobes;

  pdds_ctrl #(.LATENCY(3)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .loadStrobe (loadStrobe),
    .strobes    (strobes),
    .validOut   (sampleValid)
  );

  pdds_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .tuningWord (tuningWord),
    .samplesOut (samplesOut)
  );

  // R1: nothing is marked valid while in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !sampleValid);
endmodule

// File: tb/pdds_gen_bench.sv
module pdds_gen_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic         loadStrobe = 1'b0;
  logic [31:0]  tuningWord = '0;
  logic [127:0] samplesOut;
  logic         sampleValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pdds_gen u_pdds_gen (
    .clk(clk), .rst(rst), .enable(enable), .loadStrobe(loadStrobe),
    .tuningWord(tuningWord), .samplesOut(samplesOut), .sampleValid(sampleValid)
  );

  function automatic int refSample(input logic [31:0] ph);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(ph[31:20]) + 0.5) / 4096.0);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic int laneVal(input int k);
    return int'($signed(samplesOut[k*16 +: 16]));
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic checkEq(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      report();
    end
  end

  task automatic loadWord(input logic [31:0] w);
    @(negedge clk);
    enable = 1'b0;
    tuningWord = w;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  // Check one valid group against the per-sample reference (R3, R4)
  task automatic checkGroup(input logic [31:0] w, input int g);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] ph;
      ph = w * (32'(g) * 32'd8 + 32'(k));
      checkEq($sformatf("R3/R4 lane%0d grp%0d", k, g), laneVal(k), refSample(ph), 1);
    end
  endtask

  // Load, then stream n groups with optional pause at pauseAt (R2, R5, R6)
  task automatic runTone(input logic [31:0] w, input int n, input int pauseAt);
    int g;
    int c;
    int prev[8];
    loadWord(w);
    enable = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      checkEq("R2 valid latency", int'(sampleValid), (i == 3) ? 1 : 0, 0);
    end
    g = 0;
    c = 0;
    while (g < n) begin
      if (sampleValid) begin
        if (g == 0) checkEq("R5 lane0 after load", laneVal(0), refSample(32'd0), 1);
        checkGroup(w, g);
        if (w == 32'h2000_0000 && g > 0)
          for (int k = 0; k < 8; k++) checkEq("R7 repeat group", laneVal(k), prev[k], 0);
        if (w == 32'h8000_0000)
          for (int k = 0; k < 7; k++) checkEq("R8 alternate sign", laneVal(k + 1), -laneVal(k), 0);
        for (int k = 0; k < 8; k++) prev[k] = laneVal(k);
        g++;
      end
      if (g == pauseAt && c == 0) begin
        enable = 1'b0;
        c = 1;
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          if (sampleValid) begin
            checkGroup(w, g);
            g++;
          end
        end
        checkEq("R2 valid drop", int'(sampleValid), 0, 0);
        enable = 1'b1;
      end
      @(negedge clk);
    end
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 3) checkEq("R2 valid off", int'(sampleValid), 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 valid in reset", int'(sampleValid), 0, 0);
    checkEq("R1 samples in reset", int'(samplesOut == '0), 1, 0);
    rst = 1'b0;
    runTone(32'h0100_0000, 40, 10);   // low tone
    runTone(32'h2000_0000, 12, -1);   // R7 exactly fabric clock
    runTone(32'h3000_0000, 30, 7);    // above fabric clock
    runTone(32'h8000_0000, 10, -1);   // R8 Nyquist
    runTone(32'hC000_0000, 20, -1);   // R9 wrapped word
    runTone(32'hF123_4567, 20, 5);    // R9 near full wrap
    void'($urandom(32'd4242));
    for (int r = 0; r < 8; r++) runTone($urandom, 24, 9);
    report();
  end
endmodule